// File: doc/BRIEF.md
# Serial-Priority Interrupt Acknowledge Chain

This block links a set of interrupt sources so that they share a single request line toward a processor. Each source raises a local request. The block latches that request as pending and presents the OR of all pending bits as one request output. The processor answers with an active-low acknowledge pulse. That pulse travels along a fixed chain of links, starting at source 0. A link whose source is pending keeps the pulse. A link with nothing pending passes it on to the next lower-priority link.

The source that keeps the acknowledge is granted, and its programmable vector word appears on the shared vector output together with a valid flag. The processor uses that word to pick the service routine. When the acknowledge returns high, the granted source's pending bit is cleared. Vectors are loaded through a small configuration write port.

The vector output carries no back-pressure. The low acknowledge plays the role of the consumer's ready. The vector and its valid flag are stable for the whole pulse, and the consumer may take the word in any cycle of that pulse.

Top module: `intr_ack_chain`

## Requirements
- R1: A rising edge on `dev_req[i]` sets source i pending at that clock edge. `int_req` is high exactly while at least one source is pending, so it is visible in the cycle after the edge.
- R2: The acknowledge opens at the first clock edge where `ack_n` is sampled low after having been high. The contest at that edge uses the pending set, plus any request rising edges seen at the same edge. Grant outputs are valid from the cycle after that edge.
- R3: Priority follows the position in the chain. Source 0 is the highest priority, and among the contestants the lowest index is granted.
- R4: A source that is not pending forwards the acknowledge. `grant` is one-hot or zero, a set bit always belongs to a pending source, and `grant` is zero whenever no pulse is open.
- R5: While a grant is held, `vec_valid` is 1 and `vec_data` equals the stored vector of the granted source.
- R6: A request that rises after the pulse has opened does not change the grant, even from a higher-priority source. That request stays pending for a later pulse.
- R7: The first clock edge where `ack_n` is sampled high ends the pulse. In the following cycle `grant` is zero and `vec_valid` is 0, and only the granted source's pending bit is cleared.
- R8: A write with `cfg_we` high stores `cfg_vec` for source `cfg_idx`. A write with `cfg_idx` at or above `NUM_DEV` changes no vector.
- R9: A pulse that finds nothing pending grants nobody. `vec_data` then holds `IDLE_VEC` (default 0), `vec_valid` is 0, and the pending state is unchanged.
- R10: After reset, nothing is pending, no pulse is open, every stored vector is 0, and the outputs show the idle value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | NUM_DEV | Local request of each source, bit 0 highest priority |
| cfg_we | input | 1 | Vector write strobe |
| cfg_idx | input | IDX_W | Source index for the vector write |
| cfg_vec | input | VEC_W | Vector word to store |
| ack_n | input | 1 | Active-low acknowledge pulse from the processor |
| int_req | output | 1 | OR of all pending requests |
| grant | output | NUM_DEV | Per-source grant, one-hot or zero |
| vec_data | output | VEC_W | Vector of the granted source, or the idle value |
| vec_valid | output | 1 | High while `vec_data` carries a granted vector |

## Verification
Two events can land on the same clock edge. The first is a source's request rising edge, which sets its pending bit. The second is an acknowledge edge: a falling edge admits that request to the contest, and a rising edge clears the winner. The bench provokes both cases with directed steps and with random request and pulse timing. It includes a mid-pulse request from a higher-priority source, and a fresh rise by the winner on the very edge that ends its pulse. A reference model judges each outcome. In that model, a clear on the closing edge yields to a new rise on the same edge, and a rise on the opening edge joins the contest.

// File: rtl/intr_chain_pkg.sv
package intr_chain_pkg;
  localparam int unsigned DEF_NUM_DEV = 4;
  localparam int unsigned DEF_VEC_W   = 8;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int unsigned NUM_DEV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DEV-1:0] dev_req,
  input  logic [NUM_DEV-1:0] clr_mask,
  output logic [NUM_DEV-1:0] rise_o,
  output logic [NUM_DEV-1:0] pend_o
);
  logic [NUM_DEV-1:0] req_q;
  logic [NUM_DEV-1:0] pend_q;

  assign rise_o = dev_req & ~req_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= dev_req;
      // a new rising edge outranks a clear landing on the same edge
      pend_q <= (pend_q & ~clr_mask) | rise_o;
    end
  end

  // R1: a request edge is never lost
  a_r1_rise_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_o) |=> ((pend_q & $past(rise_o)) == $past(rise_o)));
endmodule

// File: rtl/ack_chain_link.sv
module ack_chain_link (
  input  logic ack_in,
  input  logic pend_bit,
  output logic keep,
  output logic ack_out
);
  assign keep    = ack_in & pend_bit;
  assign ack_out = ack_in & ~pend_bit;
endmodule

// File: rtl/vector_table.sv
module vector_table #(
  parameter int unsigned NUM_DEV  = 4,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned IDX_W    = 3,
  parameter logic [VEC_W-1:0] IDLE_VEC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [VEC_W-1:0]   cfg_vec,
  input  logic [NUM_DEV-1:0] grant,
  output logic [VEC_W-1:0]   vec_o,
  output logic               valid_o
);
  logic [VEC_W-1:0] vec_q [NUM_DEV];

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vec_q[i] <= '0;
      end else if (cfg_we && (cfg_idx == IDX_W'(i))) begin
        vec_q[i] <= cfg_vec;
      end
    end
  end

  always_comb begin
    logic [VEC_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      acc = acc | (vec_q[i] & {VEC_W{grant[i]}});
    end
    valid_o = |grant;
    vec_o   = valid_o ? acc : IDLE_VEC;
  end

  // R4: at most one source drives the shared word
  a_r4_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R9: without a grant the word shows the idle value
  a_r9_idle_word: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (vec_o == IDLE_VEC));
endmodule

// File: rtl/intr_ack_chain.sv
module intr_ack_chain
  import intr_chain_pkg::*;
#(
  parameter int unsigned NUM_DEV  = DEF_NUM_DEV,
  parameter int unsigned VEC_W    = DEF_VEC_W,
  parameter int unsigned IDX_W    = idx_bits(NUM_DEV),
  parameter logic [VEC_W-1:0] IDLE_VEC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DEV-1:0] dev_req,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [VEC_W-1:0]   cfg_vec,
  input  logic               ack_n,
  output logic               int_req,
  output logic [NUM_DEV-1:0] grant,
  output logic [VEC_W-1:0]   vec_data,
  output logic               vec_valid
);
  logic               ack_q;
  logic               in_pulse;
  logic               ack_fall;
  logic               ack_rise;
  logic [NUM_DEV-1:0] snap_q;
  logic [NUM_DEV-1:0] pend;
  logic [NUM_DEV-1:0] rise;
  logic [NUM_DEV-1:0] clr_mask;
  logic [NUM_DEV:0]   ack_link;

  assign ack_fall = ack_q & ~ack_n;
  assign ack_rise = ~ack_q & ack_n;
  assign clr_mask = (in_pulse && ack_rise) ? grant : '0;
  assign int_req  = |pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q    <= 1'b1;
      in_pulse <= 1'b0;
      snap_q   <= '0;
    end else begin
      ack_q <= ack_n;
      if (ack_fall) begin
        in_pulse <= 1'b1;
        snap_q   <= pend | rise;
      end else if (ack_rise) begin
        in_pulse <= 1'b0;
      end
    end
  end

  irq_pending_bank #(.NUM_DEV(NUM_DEV)) u_pend (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req),
    .clr_mask(clr_mask), .rise_o(rise), .pend_o(pend)
  );

  assign ack_link[0] = in_pulse;
  for (genvar i = 0; i < NUM_DEV; i++) begin : g_link
    ack_chain_link u_link (
      .ack_in(ack_link[i]), .pend_bit(snap_q[i]),
      .keep(grant[i]), .ack_out(ack_link[i+1])
    );
  end

  vector_table #(
    .NUM_DEV(NUM_DEV), .VEC_W(VEC_W), .IDX_W(IDX_W), .IDLE_VEC(IDLE_VEC)
  ) u_vec (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_vec(cfg_vec), .grant(grant), .vec_o(vec_data), .valid_o(vec_valid)
  );

  // R4: a grant only ever goes to a pending source
  a_r4_grant_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~pend) == '0));
  // R4: no grant while the acknowledge has been high for two samples
  a_r4_no_grant_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_n && ack_q) |-> (grant == '0));
  // R6: the grant does not move inside an open pulse
  a_r6_grant_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pulse && $past(in_pulse)) |-> $stable(grant));
  // R7: closing the pulse drops the valid flag
  a_r7_close_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rise |=> !vec_valid);
  // R7: the winner's pending bit is gone unless it rose again
  a_r7_winner_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rise && vec_valid) |=> ((pend & $past(grant & ~rise)) == '0));
endmodule

// File: tb/intr_ack_chain_test.sv
module intr_ack_chain_test;
  localparam int unsigned N  = 4;
  localparam int unsigned VW = 8;
  localparam int unsigned IW = 3;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned WATCHDOG = 100000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  dev_req;
  logic          cfg_we;
  logic [IW-1:0] cfg_idx;
  logic [VW-1:0] cfg_vec;
  logic          ack_n;
  logic          int_req;
  logic [N-1:0]  grant;
  logic [VW-1:0] vec_data;
  logic          vec_valid;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // reference model state
  logic [N-1:0]  m_pend, m_reqq, m_snap;
  logic          m_ackq, m_inp;
  logic [VW-1:0] m_vec [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_ack_chain #(.NUM_DEV(N), .VEC_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_vec(cfg_vec), .ack_n(ack_n),
    .int_req(int_req), .grant(grant), .vec_data(vec_data), .vec_valid(vec_valid)
  );

  function automatic logic [N-1:0] lowest(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return N'(1) << i;
    return '0;
  endfunction

  function automatic logic [N-1:0] exp_grant();
    return m_inp ? lowest(m_snap) : '0;
  endfunction

  function automatic logic [VW-1:0] exp_vec();
    logic [N-1:0] g = exp_grant();
    for (int i = 0; i < N; i++) if (g[i]) return m_vec[i];
    return '0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "int_req", 32'(int_req), 32'(|m_pend));
    chk(tag, "grant", 32'(grant), 32'(exp_grant()));
    chk(tag, "vec_valid", 32'(vec_valid), 32'(|exp_grant()));
    chk(tag, "vec_data", 32'(vec_data), 32'(exp_vec()));
  endtask

  // one clock: model the edge from the inputs now applied, then check
  task automatic tick(input string tag);
    logic [N-1:0] rise, clr, n_pend, n_snap;
    logic n_inp;
    rise   = dev_req & ~m_reqq;
    clr    = (m_inp && !m_ackq && ack_n) ? exp_grant() : '0;
    n_pend = (m_pend & ~clr) | rise;
    n_snap = m_snap;
    n_inp  = m_inp;
    if (m_ackq && !ack_n) begin n_inp = 1'b1; n_snap = m_pend | rise; end
    else if (!m_ackq && ack_n) n_inp = 1'b0;
    @(posedge clk);
    if (cfg_we && cfg_idx < IW'(N)) m_vec[cfg_idx[1:0]] = cfg_vec;
    m_pend = n_pend; m_snap = n_snap; m_inp = n_inp;
    m_reqq = dev_req; m_ackq = ack_n;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic write_vec(input int idx, input logic [VW-1:0] v, input string tag);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_vec = v;
    tick(tag);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int len, input string tag);
    ack_n = 1'b0;
    for (int k = 0; k < len; k++) tick(tag);
    ack_n = 1'b1;
    tick(tag);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd4242));
    rst_n = 1'b0; dev_req = '0; cfg_we = 1'b0; cfg_idx = '0; cfg_vec = '0; ack_n = 1'b1;
    m_pend = '0; m_reqq = '0; m_snap = '0; m_ackq = 1'b1; m_inp = 1'b0;
    for (int i = 0; i < N; i++) m_vec[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R10");

    // R8: program vectors, then an out-of-range write
    for (int i = 0; i < N; i++) write_vec(i, VW'(8'h20 + 8 * i), "R8");
    write_vec(5, 8'hEE, "R8");

    // R9: empty pulse
    pulse(2, "R9");

    // R1 and R5: single request then service
    dev_req = 4'b0100; tick("R1");
    dev_req = 4'b0000; tick("R1");
    pulse(2, "R5");

    // R3: simultaneous requests, lowest index wins each pulse in turn
    dev_req = 4'b1010; tick("R3");
    dev_req = 4'b0000;
    pulse(1, "R3");
    pulse(1, "R3");

    // R2: a request rising on the opening edge joins the contest
    dev_req = 4'b1000; tick("R2");
    dev_req = 4'b0010; ack_n = 1'b0; tick("R2");
    dev_req = 4'b0000; ack_n = 1'b1; tick("R2");
    pulse(1, "R2");

    // R6: higher-priority request arriving mid-pulse
    dev_req = 4'b0100; tick("R6");
    ack_n = 1'b0; tick("R6");
    dev_req = 4'b0101; tick("R6");
    tick("R6");
    ack_n = 1'b1; tick("R6");
    dev_req = 4'b0000;
    pulse(1, "R6");

    // R7: winner rises again on the closing edge; stays pending
    dev_req = 4'b0010; tick("R7");
    dev_req = 4'b0000; ack_n = 1'b0; tick("R7");
    dev_req = 4'b0010; ack_n = 1'b1; tick("R7");
    dev_req = 4'b0000;
    pulse(2, "R7");

    // R4: random traffic and vector rewrites
    for (int it = 0; it < 400; it++) begin
      dev_req = N'($urandom);
      if ($urandom_range(0, 5) == 0) begin
        cfg_we = 1'b1; cfg_idx = IW'($urandom_range(0, 7)); cfg_vec = VW'($urandom);
      end
      tick("R4");
      cfg_we = 1'b0;
      if ($urandom_range(0, 2) == 0) pulse($urandom_range(1, 3), "R4");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule